// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns a 32-bit instruction word into the control signals a single-cycle core needs to steer its datapath. It is purely combinational. The decoding happens in two levels. A primary decoder looks only at the opcode. It sets the register-destination select, the ALU operand select, the writeback select, the register and memory enables and the branch flag. It also sets a 2-bit intermediate ALU class. A secondary decoder combines that class with the function field and produces the 3-bit code that drives the ALU.

The block recognises five register-register operations: add, sub, and, or and set-on-less-than. It also recognises word load, word store and branch-if-equal. Any other opcode drives every state-changing enable low, so the machine state is left alone.

The block also combines its branch flag with the ALU zero flag from the datapath. The result is the "take branch" select for the next program counter.

Top module: `instr_ctrl_decoder`

## Requirements
- R1: The opcode is instr[31:26]. Opcode 0x00 (register-register) gives reg_dst=1, alu_src=0, mem_to_reg=0, reg_write=1, mem_read=0, mem_write=0, branch=0 and alu_op=2'b10.
- R2: Opcode 0x23 (load) gives reg_dst=0, alu_src=1, mem_to_reg=1, reg_write=1, mem_read=1, mem_write=0, branch=0 and alu_op=2'b00.
- R3: Opcode 0x2B (store) gives alu_src=1, mem_write=1 and alu_op=2'b00. All other outputs of the primary decoder, including reg_dst and mem_to_reg, are 0.
- R4: Opcode 0x04 (branch-if-equal) gives branch=1 and alu_op=2'b01. All other outputs of the primary decoder are 0.
- R5: Any other opcode drives every primary output to 0 and gives alu_op=2'b00. No register or memory write and no branch can then occur.
- R6: alu_op 2'b00 gives alu_ctl=3'b010 (add). alu_op 2'b01 gives alu_ctl=3'b110 (subtract).
- R7: With alu_op 2'b10, the function field instr[5:0] selects alu_ctl: 0x20→010, 0x22→110, 0x24→000, 0x25→001, 0x2A→111. Any other function value gives 010.
- R8: take_branch equals branch AND alu_zero.
- R9: instr[25:6] never affects any output. instr[5:0] affects no output unless the opcode is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| alu_zero | input | 1 | Zero flag from the datapath ALU |
| reg_dst | output | 1 | 1: write register from instr[15:11]; 0: from instr[20:16] |
| alu_src | output | 1 | 1: second ALU operand is the sign-extended immediate |
| mem_to_reg | output | 1 | 1: writeback data comes from data memory |
| reg_write | output | 1 | Register file write enable |
| mem_read | output | 1 | Data memory read enable |
| mem_write | output | 1 | Data memory write enable |
| branch | output | 1 | Instruction is a conditional branch |
| alu_op | output | 2 | Intermediate ALU class |
| alu_ctl | output | 3 | ALU operation code |
| take_branch | output | 1 | Select branch target as next PC |

## Verification
Two things happen in the same evaluation: the function-field lookup of the secondary decoder and the branch resolution that gates on the flag from the primary decoder. The bench provokes a collision by sending branch and register-register words whose unused bit fields hold function codes that look valid. It drives alu_zero both ways at the same moment. A reference model, written independently and applied to every vector, judges the result. It expects the function bits to change alu_ctl only for opcode 0x00, and it expects take_branch to follow alu_zero only for opcode 0x04.

// File: rtl/instr_ctrl_decoder.sv
module instr_ctrl_decoder (
  input  logic [31:0] instr,
  input  logic        alu_zero,
  output logic        reg_dst,
  output logic        alu_src,
  output logic        mem_to_reg,
  output logic        reg_write,
  output logic        mem_read,
  output logic        mem_write,
  output logic        branch,
  output logic [1:0]  alu_op,
  output logic [2:0]  alu_ctl,
  output logic        take_branch
);

  localparam logic [5:0] OPC_RRR  = 6'h00;
  localparam logic [5:0] OPC_LOAD = 6'h23;
  localparam logic [5:0] OPC_STOR = 6'h2B;
  localparam logic [5:0] OPC_BEQ  = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  localparam logic [1:0] CLS_MEM  = 2'b00;
  localparam logic [1:0] CLS_CMP  = 2'b01;
  localparam logic [1:0] CLS_FUNC = 2'b10;

  localparam logic [2:0] ALU_AND = 3'b000;
  localparam logic [2:0] ALU_OR  = 3'b001;
  localparam logic [2:0] ALU_ADD = 3'b010;
  localparam logic [2:0] ALU_SUB = 3'b110;
  localparam logic [2:0] ALU_SLT = 3'b111;

  logic [5:0] opc;
  logic [5:0] fn;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  // primary level: opcode only
  always_comb begin : main_dec
    reg_dst    = 1'b0;
    alu_src    = 1'b0;
    mem_to_reg = 1'b0;
    reg_write  = 1'b0;
    mem_read   = 1'b0;
    mem_write  = 1'b0;
    branch     = 1'b0;
    alu_op     = CLS_MEM;
    case (opc)
      OPC_RRR: begin
        reg_dst   = 1'b1;
        reg_write = 1'b1;
        alu_op    = CLS_FUNC;
      end
      OPC_LOAD: begin
        alu_src    = 1'b1;
        mem_to_reg = 1'b1;
        reg_write  = 1'b1;
        mem_read   = 1'b1;
      end
      OPC_STOR: begin
        alu_src   = 1'b1;
        mem_write = 1'b1;
      end
      OPC_BEQ: begin
        branch = 1'b1;
        alu_op = CLS_CMP;
      end
      default: ;
    endcase

    a_r5_one_side_effect: assert ($onehot0({mem_read, mem_write, branch}));
    a_r4_branch_quiet: assert (!(branch && (reg_write || alu_src || mem_to_reg)));
    a_r2_load_path: assert (!mem_to_reg || (mem_read && alu_src && reg_write));
    a_r3_store_no_reg: assert (!(mem_write && (reg_write || reg_dst)));
    a_r1_rdst_func: assert (!reg_dst || alu_op == CLS_FUNC);
  end

  // secondary level: class plus function field
  always_comb begin : alu_dec
    case (alu_op)
      CLS_MEM: alu_ctl = ALU_ADD;
      CLS_CMP: alu_ctl = ALU_SUB;
      CLS_FUNC: begin
        case (fn)
          FN_ADD:  alu_ctl = ALU_ADD;
          FN_SUB:  alu_ctl = ALU_SUB;
          FN_AND:  alu_ctl = ALU_AND;
          FN_OR:   alu_ctl = ALU_OR;
          FN_SLT:  alu_ctl = ALU_SLT;
          default: alu_ctl = ALU_ADD;
        endcase
      end
      default: alu_ctl = ALU_ADD;
    endcase

    a_r7_ctl_legal: assert (alu_ctl inside {ALU_AND, ALU_OR, ALU_ADD, ALU_SUB, ALU_SLT});
    a_r6_nonfunc_arith: assert (alu_op == CLS_FUNC || alu_ctl inside {ALU_ADD, ALU_SUB});
  end

  assign take_branch = branch & alu_zero;

endmodule

// File: tb/tb_instr_ctrl_decoder.sv
module tb_instr_ctrl_decoder;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] instr = 32'h0;
  logic        alu_zero = 1'b0;
  logic reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write, branch, take_branch;
  logic [1:0] alu_op;
  logic [2:0] alu_ctl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  instr_ctrl_decoder dut (
    .instr(instr), .alu_zero(alu_zero), .reg_dst(reg_dst), .alu_src(alu_src),
    .mem_to_reg(mem_to_reg), .reg_write(reg_write), .mem_read(mem_read),
    .mem_write(mem_write), .branch(branch), .alu_op(alu_op), .alu_ctl(alu_ctl),
    .take_branch(take_branch)
  );

  // order: rdst asrc m2r rw mr mw br op[1:0] ctl[2:0] take
  function automatic logic [12:0] model(input logic [31:0] w, input logic z);
    int op = int'(w[31:26]);
    int fn = int'(w[5:0]);
    logic [6:0] f = 7'b0;
    logic [1:0] cls = 2'b00;
    logic [2:0] c;
    if (op == 0)         begin f = 7'b1001000; cls = 2'b10; end
    else if (op == 'h23) f = 7'b0111100;
    else if (op == 'h2B) f = 7'b0100010;
    else if (op == 4)    begin f = 7'b0000001; cls = 2'b01; end
    if (cls == 2'b01) c = 3'b110;
    else if (cls == 2'b10)
      c = (fn == 'h22) ? 3'b110 : (fn == 'h24) ? 3'b000 :
          (fn == 'h25) ? 3'b001 : (fn == 'h2A) ? 3'b111 : 3'b010;
    else c = 3'b010;
    return {f, cls, c, f[0] & z};
  endfunction

  function automatic string tag(input logic [31:0] w);
    case (w[31:26])
      6'h00: return "R1/R7";
      6'h23: return "R2/R6";
      6'h2B: return "R3/R6";
      6'h04: return "R4/R8";
      default: return "R5";
    endcase
  endfunction

  task automatic apply(input logic [31:0] w, input logic z, input string req);
    logic [12:0] got, exp;
    @(posedge clk);
    #1;
    instr = w;
    alu_zero = z;
    @(negedge clk);
    got = {reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write, branch,
           alu_op, alu_ctl, take_branch};
    exp = model(w, z);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s instr=%h zero=%0b actual=%b expected=%b", req, w, z, got, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [19:0] mid, input logic [5:0] fn);
    return {op, mid, fn};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [5:0] fns [6] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A, 6'h21};
    logic [5:0] ops [5] = '{6'h00, 6'h23, 6'h2B, 6'h04, 6'h02};
    apply(32'h0, 1'b0, "R1 initial all-zero word");
    for (int i = 0; i < 6; i++) apply(mk(6'h00, 20'h12345, fns[i]), 1'b1, "R7 function field");
    apply(mk(6'h23, 20'h0, 6'h0), 1'b0, "R2 load");
    apply(mk(6'h2B, 20'hFFFFF, 6'h2A), 1'b1, "R3 store ignores funct");
    apply(mk(6'h04, 20'h0, 6'h22), 1'b1, "R4 R8 beq taken");
    apply(mk(6'h04, 20'h0, 6'h25), 1'b0, "R4 R8 beq not taken");
    apply(mk(6'h00, 20'h0, 6'h2A), 1'b1, "R8 rtype zero high no take");
    apply(mk(6'h08, 20'h0, 6'h20), 1'b1, "R5 unknown opcode");
    apply(mk(6'h3F, 20'hFFFFF, 6'h3F), 1'b1, "R5 unknown all ones");
    apply(mk(6'h23, 20'hABCDE, 6'h24), 1'b1, "R9 load upper bits ignored");
    apply(mk(6'h2B, 20'h00000, 6'h24), 1'b0, "R6 store address add");
    for (int op = 0; op < 64; op++)
      apply(mk(6'(op), 20'h5A5A5, 6'h22), op[0], tag(mk(6'(op), 20'h0, 6'h0)));
    for (int i = 0; i < 400; i++) begin
      logic [5:0] op = ops[$urandom_range(0, 4)];
      logic [5:0] fn = ($urandom_range(0, 1) != 0) ? fns[$urandom_range(0, 5)] : 6'($urandom);
      logic [31:0] w = mk(op, 20'($urandom), fn);
      apply(w, 1'($urandom), {tag(w), " R9 random"});
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule